// File: doc/BRIEF.md
# Touch Confirmation and Group Suppression Filter

This block turns per-key capacitive acquisitions into a debounced, arbitrated key status word for a 16-key matrix. Each acquisition presents a key number, the measured signal delta and that key's threshold. A per-key consecutive-hit counter confirms a touch only after an unbroken run of above-threshold acquisitions. A release takes effect on the first acquisition at or below threshold.

At the end of each scan the confirmed keys pass through three suppression groups. In each group exactly one object is reported. The first object to confirm holds the group until it is released. A slider made of keys 0 up to L-1 acts as a single object in its group, and its member keys never suppress one another. When the reported word changes, a one-cycle change flag is raised.

Top module: `touch_confirm`

## Requirements
- R1: An acquisition counts as a hit only when the signed delta is strictly greater than the signed threshold; a delta equal to the threshold is a miss.
- R2: A key becomes confirmed once its hit counter reaches the detection limit. The counter advances by one per hit and saturates at the limit.
- R3: Any miss clears that key's counter to zero, so a confirmed key is released by a single miss, with no integration on release.
- R4: A detection limit of 0 behaves as a limit of 1.
- R5: `key_status` and `change` update only on the clock edge where `scan_done` is high. An acquisition presented in that same cycle is included in the update.
- R6: A key whose group field is 0 reports its confirmed state directly. The group of key k is `key_group[2k+1:2k]`, with values 0 to 3.
- R7: In groups 1 to 3, the object reported at one scan end stays the group's only reported object while it remains confirmed and in that group, even if other members confirm later.
- R8: When a group has no held object, the confirmed object with the lowest key number wins it. The slider counts as key number 0.
- R9: With a slider length L (values below 2 mean no slider, values above 8 count as 8), keys 0 to L-1 form one object. Any number of them may be reported at once.
- R10: The slider object belongs to the group given by key 0's field. When it holds the group, every other group member is suppressed. When another member holds the group, every slider key is suppressed.
- R11: `change` is high for exactly the one cycle after a scan end whose new `key_status` differs from the previous one.
- R12: After reset, `key_status` is zero, `change` is low, all counters are zero and no group is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_valid | input | 1 | One key acquisition is presented this cycle |
| acq_key | input | 4 | Key number of the acquisition |
| acq_delta | input | 12 | Signed signal delta |
| acq_thresh | input | 12 | Signed touch threshold for that key |
| det_limit | input | 4 | Consecutive hits needed to confirm |
| key_group | input | 32 | Two-bit group field per key |
| slider_len | input | 4 | Number of slider keys starting at key 0 |
| scan_done | input | 1 | End of scan: update the reported status |
| key_status | output | 16 | Reported touch bit per key |
| change | output | 1 | Reported status differed from previous scan |

## Verification
The integrator and the group arbiter can act in the same cycle, when the final acquisition of a scan arrives together with `scan_done`. The arbiter must then see the counter value that this acquisition just produced. The bench places `scan_done` on the last acquisition of every scan, so a confirmation or release decided by that last key shows up in the very word reported. The result is judged against a bench model and against directed scans, where a lower key confirms on the closing acquisition while a held object is released in that same scan.

// File: rtl/touch_pkg.sv
package touch_pkg;
  localparam int NUM_GROUPS = 3;
  localparam int GRP_W      = 2;
  typedef logic [GRP_W-1:0] grp_t;
endpackage

// File: rtl/key_integrator.sv
module key_integrator #(
  parameter int NKEYS = 16,
  parameter int DW    = 12,
  parameter int CW    = 4,
  localparam int KW   = $clog2(NKEYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acq_valid,
  input  logic [KW-1:0]        acq_key,
  input  logic signed [DW-1:0] acq_delta,
  input  logic signed [DW-1:0] acq_thresh,
  input  logic [CW-1:0]        det_limit,
  output logic [NKEYS-1:0]     conf_next
);
  logic [CW-1:0] lim_eff;
  logic          above;

  always_comb begin
    lim_eff = (det_limit == '0) ? CW'(1) : det_limit;
    above   = acq_delta > acq_thresh;
  end

  for (genvar k = 0; k < NKEYS; k++) begin : g_key
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hit_en;

    always_comb begin
      hit_en = acq_valid && (acq_key == KW'(k));
      cnt_d  = cnt_q;
      if (hit_en) begin
        if (!above)              cnt_d = '0;
        else if (cnt_q < lim_eff) cnt_d = cnt_q + CW'(1);
      end
      conf_next[k] = cnt_d >= lim_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (hit_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/group_arbiter.sv
module group_arbiter #(
  parameter int NKEYS = 16,
  localparam int KW   = $clog2(NKEYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_done,
  input  logic [NKEYS-1:0] obj_det,
  input  logic [NKEYS-1:0] obj_member,
  output logic             win_valid,
  output logic [KW-1:0]    win_id
);
  logic          hold_v_q;
  logic [KW-1:0] hold_id_q;
  logic          keep;

  always_comb begin
    keep      = hold_v_q && obj_det[hold_id_q] && obj_member[hold_id_q];
    win_valid = keep;
    win_id    = hold_id_q;
    if (!keep) begin
      win_valid = 1'b0;
      win_id    = '0;
      for (int k = NKEYS - 1; k >= 0; k--) begin
        if (obj_det[k] && obj_member[k]) begin
          win_valid = 1'b1;
          win_id    = KW'(k);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v_q  <= 1'b0;
      hold_id_q <= '0;
    end else if (scan_done) begin
      hold_v_q  <= win_valid;
      hold_id_q <= win_id;
    end
  end
endmodule

// File: rtl/touch_confirm.sv
module touch_confirm #(
  parameter int NKEYS      = 16,
  parameter int DW         = 12,
  parameter int CW         = 4,
  parameter int MAX_SLIDER = 8,
  localparam int KW        = $clog2(NKEYS),
  localparam int SLW       = $clog2(MAX_SLIDER + 1),
  localparam int GW        = touch_pkg::GRP_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acq_valid,
  input  logic [KW-1:0]        acq_key,
  input  logic signed [DW-1:0] acq_delta,
  input  logic signed [DW-1:0] acq_thresh,
  input  logic [CW-1:0]        det_limit,
  input  logic [NKEYS*GW-1:0]  key_group,
  input  logic [SLW-1:0]       slider_len,
  input  logic                 scan_done,
  output logic [NKEYS-1:0]     key_status,
  output logic                 change
);
  import touch_pkg::*;

  logic [NKEYS-1:0] conf_next;
  logic [NKEYS-1:0] slide_mask;
  logic [NKEYS-1:0] obj_det;
  logic [SLW-1:0]   slide_eff;
  grp_t             eff_grp [NKEYS];
  logic             win_v   [NUM_GROUPS+1];
  logic [KW-1:0]    win_id  [NUM_GROUPS+1];
  logic [NKEYS-1:0] status_d;
  logic [NKEYS-1:0] status_q;
  logic             change_q;

  key_integrator #(.NKEYS(NKEYS), .DW(DW), .CW(CW)) u_integ (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_valid (acq_valid),
    .acq_key   (acq_key),
    .acq_delta (acq_delta),
    .acq_thresh(acq_thresh),
    .det_limit (det_limit),
    .conf_next (conf_next)
  );

  always_comb begin
    if (slider_len < SLW'(2))               slide_eff = '0;
    else if (slider_len > SLW'(MAX_SLIDER)) slide_eff = SLW'(MAX_SLIDER);
    else                                    slide_eff = slider_len;
    for (int k = 0; k < NKEYS; k++) begin
      slide_mask[k] = k < int'(slide_eff);
      eff_grp[k]    = slide_mask[k] ? grp_t'(key_group[GW-1:0])
                                    : grp_t'(key_group[k*GW +: GW]);
      if (k == 0 && slide_mask[0]) obj_det[k] = |(conf_next & slide_mask);
      else                         obj_det[k] = slide_mask[k] ? 1'b0 : conf_next[k];
    end
  end

  assign win_v[0]  = 1'b0;
  assign win_id[0] = '0;

  for (genvar g = 1; g <= NUM_GROUPS; g++) begin : g_grp
    logic [NKEYS-1:0] member;
    always_comb begin
      for (int k = 0; k < NKEYS; k++) member[k] = eff_grp[k] == grp_t'(g);
    end
    group_arbiter #(.NKEYS(NKEYS)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .scan_done (scan_done),
      .obj_det   (obj_det),
      .obj_member(member),
      .win_valid (win_v[g]),
      .win_id    (win_id[g])
    );
  end

  always_comb begin
    for (int k = 0; k < NKEYS; k++) begin
      if (eff_grp[k] == '0) begin
        status_d[k] = conf_next[k];
      end else begin
        status_d[k] = conf_next[k] && win_v[eff_grp[k]] &&
                      (win_id[eff_grp[k]] == (slide_mask[k] ? KW'(0) : KW'(k)));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      change_q <= 1'b0;
    end else begin
      change_q <= scan_done && (status_d != status_q);
      if (scan_done) status_q <= status_d;
    end
  end

  assign key_status = status_q;
  assign change     = change_q;
endmodule

// File: rtl/touch_confirm_chk.sv
module touch_confirm_chk #(
  parameter int NKEYS      = 16,
  parameter int MAX_SLIDER = 8,
  parameter int GW         = 2,
  parameter int SLW        = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                scan_done,
  input logic [NKEYS*GW-1:0] key_group,
  input logic [SLW-1:0]      slider_len,
  input logic [NKEYS-1:0]    key_status,
  input logic                change
);
  logic [NKEYS-1:0] solo_q [4];
  logic [NKEYS-1:0] slide_q;
  logic [1:0]       slide_grp_q;
  logic             groups_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 4; g++) solo_q[g] <= '0;
      slide_q     <= '0;
      slide_grp_q <= '0;
    end else if (scan_done) begin
      for (int g = 0; g < 4; g++) begin
        for (int k = 0; k < NKEYS; k++) begin
          solo_q[g][k] <= !(slider_len >= SLW'(2) && k < int'(slider_len) && k < MAX_SLIDER)
                          && key_group[k*GW +: GW] == 2'(g);
        end
      end
      for (int k = 0; k < NKEYS; k++)
        slide_q[k] <= slider_len >= SLW'(2) && k < int'(slider_len) && k < MAX_SLIDER;
      slide_grp_q <= key_group[1:0];
    end
  end

  always_comb begin
    groups_ok = 1'b1;
    for (int g = 1; g < 4; g++) begin
      if ($countones(key_status & solo_q[g]) +
          ((slide_grp_q == 2'(g) && |(key_status & slide_q)) ? 1 : 0) > 1)
        groups_ok = 1'b0;
    end
  end

  // R5: reported word moves only at a scan end
  p_status_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |=> $stable(key_status));

  // R11: flag follows a scan end that altered the word
  p_change_value_r11: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> change == (key_status != $past(key_status)));

  // R11: flag never rises without a scan end before it
  p_change_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_done |=> !change);

  // R7 R10: at most one object reported per group
  p_one_per_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
    groups_ok);
endmodule

bind touch_confirm touch_confirm_chk #(
  .NKEYS(NKEYS), .MAX_SLIDER(MAX_SLIDER), .GW(GW), .SLW(SLW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scan_done (scan_done),
  .key_group (key_group),
  .slider_len(slider_len),
  .key_status(key_status),
  .change    (change)
);

// File: tb/sim_touch_confirm.sv
module sim_touch_confirm;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               acq_valid;
  logic [3:0]         acq_key;
  logic signed [11:0] acq_delta;
  logic signed [11:0] acq_thresh;
  logic [3:0]         det_limit;
  logic [31:0]        key_group;
  logic [3:0]         slider_len;
  logic               scan_done;
  logic [15:0]        key_status;
  logic               change;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  int        mcnt [16];
  bit        mhold_v [4];
  int        mhold_id [4];
  logic [15:0] mstat;
  bit        mchg;

  always #2 clk = ~clk;

  touch_confirm u0 (
    .clk(clk), .rst_n(rst_n), .acq_valid(acq_valid), .acq_key(acq_key),
    .acq_delta(acq_delta), .acq_thresh(acq_thresh), .det_limit(det_limit),
    .key_group(key_group), .slider_len(slider_len), .scan_done(scan_done),
    .key_status(key_status), .change(change)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int lim_of();
    return (det_limit == 0) ? 1 : int'(det_limit);
  endfunction

  function automatic int slide_of();
    if (slider_len < 2) return 0;
    if (slider_len > 8) return 8;
    return int'(slider_len);
  endfunction

  // model of scan end, built from R6-R10
  task automatic model_scan();
    int sl, lim;
    int eg [16];
    bit conf [16];
    bit od [16];
    logic [15:0] st;
    sl = slide_of(); lim = lim_of();
    for (int k = 0; k < 16; k++) begin
      conf[k] = mcnt[k] >= lim;
      eg[k]   = (k < sl) ? int'(key_group[1:0]) : int'(key_group[2*k +: 2]);
    end
    for (int k = 0; k < 16; k++) begin
      if (k == 0 && sl > 0) begin
        od[k] = 0;
        for (int j = 0; j < sl; j++) od[k] |= conf[j];
      end else od[k] = (k < sl) ? 0 : conf[k];
    end
    for (int g = 1; g < 4; g++) begin
      if (!(mhold_v[g] && od[mhold_id[g]] && eg[mhold_id[g]] == g)) begin
        mhold_v[g] = 0; mhold_id[g] = 0;
        for (int k = 0; k < 16; k++)
          if (!mhold_v[g] && od[k] && eg[k] == g) begin mhold_v[g] = 1; mhold_id[g] = k; end
      end
    end
    for (int k = 0; k < 16; k++) begin
      if (eg[k] == 0) st[k] = conf[k];
      else st[k] = conf[k] && mhold_v[eg[k]] && mhold_id[eg[k]] == ((k < sl) ? 0 : k);
    end
    mchg  = st != mstat;
    mstat = st;
  endtask

  task automatic acq(int k, int d, bit done, string tag);
    int lim;
    @(negedge clk);
    acq_valid = 1; acq_key = 4'(k); acq_delta = 12'(d); acq_thresh = 12'sd20;
    scan_done = done;
    lim = lim_of();
    if (d > 20) begin if (mcnt[k] < lim) mcnt[k]++; end
    else mcnt[k] = 0;
    if (done) model_scan();
    @(negedge clk);
    acq_valid = 0; scan_done = 0;
    if (done) begin
      check({tag, " status"}, 32'(key_status), 32'(mstat));
      check({tag, " change R11"}, 32'(change), 32'(mchg));
    end
  endtask

  // one scan: bit set in hits means delta above threshold; last acquisition carries scan_done (R5)
  task automatic scan(logic [15:0] hits, string tag);
    for (int k = 0; k < 16; k++) acq(k, hits[k] ? 40 : 5, k == 15, tag);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] h;
    int d;
    rst_n = 0; acq_valid = 0; acq_key = 0; acq_delta = 0; acq_thresh = 20;
    det_limit = 1; key_group = '0; slider_len = 0; scan_done = 0;
    for (int k = 0; k < 16; k++) mcnt[k] = 0;
    for (int g = 0; g < 4; g++) begin mhold_v[g] = 0; mhold_id[g] = 0; end
    mstat = '0; mchg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R12 reset status", 32'(key_status), 32'h0);
    check("R12 reset change", 32'(change), 32'h0);

    // R1: equal is a miss, one above is a hit
    acq(5, 20, 1, "R1 equal");
    check("R1 equal no touch", 32'(key_status[5]), 32'h0);
    acq(5, 21, 1, "R1 above");
    check("R1 above touch", 32'(key_status[5]), 32'h1);
    // R3: single miss releases
    acq(5, -3, 1, "R3 release");
    check("R3 released", 32'(key_status[5]), 32'h0);

    // R2: limit 3 needs three unbroken hits
    det_limit = 3;
    acq(7, 30, 1, "R2 hit1");
    acq(7, 30, 1, "R2 hit2");
    check("R2 not yet", 32'(key_status[7]), 32'h0);
    acq(7, 0, 1, "R3 break");
    acq(7, 30, 1, "R2 hitA");
    acq(7, 30, 1, "R2 hitB");
    check("R3 counter restarted", 32'(key_status[7]), 32'h0);
    acq(7, 30, 1, "R2 hitC");
    check("R2 confirmed", 32'(key_status[7]), 32'h1);
    // R4: limit 0 acts as 1
    det_limit = 0;
    acq(7, 0, 1, "R4 clear");
    acq(7, 30, 1, "R4 one hit");
    check("R4 limit zero", 32'(key_status[7]), 32'h1);
    acq(7, 0, 1, "R4 clear2");

    // R8 R7: all keys in group 1
    det_limit = 1; key_group = {16{2'b01}};
    scan(16'h0208, "R8 tie");
    check("R8 lowest wins", 32'(key_status), 32'h0008);
    scan(16'h000A, "R7 hold");
    check("R7 held key stays", 32'(key_status), 32'h0008);
    scan(16'h0002, "R7 handover");
    check("R7 next takes over", 32'(key_status), 32'h0002);
    // R6: group 0 key unaffected by group 1 activity
    key_group[2*12 +: 2] = 2'b00;
    scan(16'h1002, "R6 free key");
    check("R6 group0 raw", 32'(key_status), 32'h1002);

    // R9 R10: slider of four keys in group 1
    slider_len = 4; key_group = {16{2'b01}};
    scan(16'h0000, "R9 idle");
    scan(16'h0006, "R9 multi");
    check("R9 slider keys together", 32'(key_status), 32'h0006);
    scan(16'h0046, "R10 slider holds");
    check("R10 slider suppresses key", 32'(key_status), 32'h0006);
    scan(16'h0040, "R10 key takes");
    check("R10 key after slider", 32'(key_status), 32'h0040);
    scan(16'h0041, "R10 slider suppressed");
    check("R10 key suppresses slider", 32'(key_status), 32'h0040);
    slider_len = 12;
    scan(16'h0000, "R9 clamp idle");
    scan(16'h0180, "R9 clamp");
    check("R9 length clamps to eight", 32'(key_status), 32'h0080);
    scan(16'h0180, "R11 steady");
    check("R11 no change", 32'(change), 32'h0);

    // random scans checked against the model (R1-R11)
    void'($urandom(32'd1234));
    for (int s = 0; s < 80; s++) begin
      if (s % 8 == 0) begin
        det_limit  = 4'($urandom_range(0, 4));
        key_group  = $urandom;
        slider_len = 4'($urandom_range(0, 10));
      end
      for (int k = 0; k < 16; k++) begin
        if ($urandom_range(0, 9) == 0 && k != 15) continue;
        d = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 20)) - 10
                                        : int'($urandom_range(18, 60));
        acq(k, d, k == 15, "R7 random");
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule